// File: doc/BRIEF.md
# ADC Gain Trim Search Controller

This block finds the gain trim code for an analog-to-digital converter by successive approximation. A start pulse launches a search over a 7-bit trim code. The search begins at the midpoint code, with only the top bit set. For each trial, the controller asks the converter for one calibration-mode conversion at the current trial code. It then compares the 12-bit raw result with a programmable target code, and either keeps or clears the bit under test. The search then moves on to the next lower bit. After seven trials, the code that is left is the calibrated gain trim.

The target is an input, so software can place it a few LSBs inside full scale and avoid overshoot. A mode input selects the comparison direction:

- **Normal mode** (single-ended or differential): the result rises with the trim code.
- **Negative mode** (negative single-ended): the result falls with the trim code.

A search is only accepted once offset calibration has been reported complete.

The conversion request and the returned result both travel over valid/ready handshakes:

- **Request side:** the controller raises the request valid and holds it, with the trial code stable, until the converter signals ready. The converter may hold ready low for any number of cycles.
- **Result side:** the controller raises result ready only while it waits for a result. A result offered at any other time is neither consumed nor acknowledged, so the converter keeps it pending.

Top module: `gain_trim_search`

## Requirements
- R1: A start pulse while the offset-done input is low is refused. Busy stays low, no conversion request is raised, and the trim output keeps its value.
- R2: In the cycle after an accepted start, busy is high, the trim output is 0x40 (only bit 6 set) and the first conversion request is raised. The calibration enable output is high whenever a request is raised.
- R3: Every search issues exactly seven accepted conversion requests, one per trim bit, from bit 6 down to bit 0.
- R4: In normal mode (mode input 0), a trial bit is kept when the result is less than or equal to the target, and cleared otherwise. The final code is the largest code whose result does not exceed the target, or 0 if no code qualifies.
- R5: In negative mode (mode input 1), a trial bit is kept when the result is greater than or equal to the target, and cleared otherwise. The final code is the largest code whose result is not below the target, or 0 if no code qualifies.
- R6: The target and mode are captured when a start is accepted. The search uses the captured values throughout.
- R7: Busy stays high from the cycle after an accepted start until done. A start pulse while busy is ignored and does not restart the search.
- R8: Done pulses for exactly one cycle, in the cycle after the seventh result is accepted. In that same cycle, busy is already low. The final trim stays unchanged until the next accepted start.
- R9: A raised request holds its valid and trim code stable until ready is seen. Result ready is high only while a result is awaited. Request valid and result ready are never high in the same cycle.
- R10: After reset, busy, done, request valid, result ready and calibration enable are low, and the trim output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for a search |
| offset_done_i | input | 1 | Offset calibration has been completed |
| neg_mode_i | input | 1 | 1 selects negative single-ended compare direction |
| target_i | input | 12 | Target raw code for the comparison |
| conv_valid_o | output | 1 | Conversion request valid |
| conv_ready_i | input | 1 | Converter accepts the request |
| cal_en_o | output | 1 | Calibration mode enable toward the converter |
| trim_o | output | 7 | Current trial or final gain trim code |
| res_valid_i | input | 1 | Conversion result valid |
| res_data_i | input | 12 | Raw conversion result |
| res_ready_o | output | 1 | Controller accepts a result |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse when the search completes |

## Verification
The results have fixed timing relative to their stimulus:

- The first request and busy appear one cycle after the clock edge that accepts a start.
- Each new trial code and its request appear one cycle after the edge that accepts a result.
- Done and the final code appear one cycle after the seventh result is accepted.

The bench drives inputs and samples outputs on the falling edge, so each of these results is read half a cycle after the edge that produced it. The converter model inserts random delays on both handshakes to stretch the waits without moving these relations. Final codes are checked against the largest qualifying code found by a bench-side scan of a monotonic transfer function.

// File: rtl/gts_pkg.sv
package gts_pkg;
  typedef enum logic [1:0] {
    GTS_IDLE = 2'd0,
    GTS_REQ  = 2'd1,
    GTS_WAIT = 2'd2
  } gts_state_e;
endpackage

// File: rtl/gts_seq.sv
module gts_seq
  import gts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_ok,
  input  logic       req_ready,
  input  logic       res_valid,
  input  logic       last_bit,
  output gts_state_e state,
  output logic       load,
  output logic       advance,
  output logic       finish
);
  gts_state_e state_q, state_d;

  assign state   = state_q;
  assign load    = (state_q == GTS_IDLE) && start_ok;
  assign advance = (state_q == GTS_WAIT) && res_valid;
  assign finish  = advance && last_bit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GTS_IDLE: if (start_ok)  state_d = GTS_REQ;
      GTS_REQ:  if (req_ready) state_d = GTS_WAIT;
      GTS_WAIT: if (res_valid) state_d = last_bit ? GTS_IDLE : GTS_REQ;
      default:                 state_d = GTS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GTS_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/gts_cmp.sv
module gts_cmp #(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] result,
  input  logic [DATA_W-1:0] target,
  input  logic              neg_mode,
  output logic              keep
);
  logic at_or_below;
  logic at_or_above;

  assign at_or_below = (result <= target);
  assign at_or_above = (result >= target);
  assign keep        = neg_mode ? at_or_above : at_or_below;
endmodule

// File: rtl/gts_trim.sv
module gts_trim #(
  parameter int TRIM_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic              keep,
  output logic [TRIM_W-1:0] trim,
  output logic              last_bit
);
  localparam logic [TRIM_W-1:0] MSB_ONEHOT = {1'b1, {(TRIM_W-1){1'b0}}};

  logic [TRIM_W-1:0] ptr_q;
  logic [TRIM_W-1:0] trim_q;
  logic [TRIM_W-1:0] ptr_next;
  logic [TRIM_W-1:0] trim_step;

  assign ptr_next = ptr_q >> 1;
  assign last_bit = ptr_q[0];
  assign trim     = trim_q;

  for (genvar b = 0; b < TRIM_W; b++) begin : g_bit
    always_comb begin
      if (ptr_q[b])         trim_step[b] = keep;
      else if (ptr_next[b]) trim_step[b] = 1'b1;
      else                  trim_step[b] = trim_q[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      trim_q <= '0;
    end else if (load) begin
      ptr_q  <= MSB_ONEHOT;
      trim_q <= MSB_ONEHOT;
    end else if (advance) begin
      ptr_q  <= ptr_next;
      trim_q <= trim_step;
    end
  end
endmodule

// File: rtl/gain_trim_search.sv
module gain_trim_search
  import gts_pkg::*;
#(
  parameter int TRIM_W = 7,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              offset_done_i,
  input  logic              neg_mode_i,
  input  logic [DATA_W-1:0] target_i,
  output logic              conv_valid_o,
  input  logic              conv_ready_i,
  output logic              cal_en_o,
  output logic [TRIM_W-1:0] trim_o,
  input  logic              res_valid_i,
  input  logic [DATA_W-1:0] res_data_i,
  output logic              res_ready_o,
  output logic              busy_o,
  output logic              done_o
);
  gts_state_e        state;
  logic              load, advance, finish, keep, last_bit;
  logic              neg_q, done_q;
  logic [DATA_W-1:0] target_q;

  gts_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ok  (start_i && offset_done_i),
    .req_ready (conv_ready_i),
    .res_valid (res_valid_i),
    .last_bit  (last_bit),
    .state     (state),
    .load      (load),
    .advance   (advance),
    .finish    (finish)
  );

  gts_cmp #(.DATA_W(DATA_W)) u_cmp (
    .result   (res_data_i),
    .target   (target_q),
    .neg_mode (neg_q),
    .keep     (keep)
  );

  gts_trim #(.TRIM_W(TRIM_W)) u_trim (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .advance  (advance),
    .keep     (keep),
    .trim     (trim_o),
    .last_bit (last_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q    <= 1'b0;
      target_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= finish;
      if (load) begin
        neg_q    <= neg_mode_i;
        target_q <= target_i;
      end
    end
  end

  assign busy_o       = (state != GTS_IDLE);
  assign cal_en_o     = busy_o;
  assign conv_valid_o = (state == GTS_REQ);
  assign res_ready_o  = (state == GTS_WAIT);
  assign done_o       = done_q;
endmodule

// File: rtl/gts_checker.sv
module gts_checker #(
  parameter int TRIM_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              offset_done_i,
  input logic              conv_valid_o,
  input logic              conv_ready_i,
  input logic              cal_en_o,
  input logic [TRIM_W-1:0] trim_o,
  input logic              res_ready_o,
  input logic              busy_o,
  input logic              done_o
);
  localparam int CNT_W = $clog2(TRIM_W + 1) + 1;
  localparam logic [TRIM_W-1:0] FIRST_CODE = {1'b1, {(TRIM_W-1){1'b0}}};

  logic [CNT_W-1:0] req_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           req_cnt <= '0;
    else if (!busy_o)                     req_cnt <= '0;
    else if (conv_valid_o && conv_ready_i) req_cnt <= req_cnt + 1'b1;
  end

  // R1
  refuse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !offset_done_i) |=> !busy_o);

  // R2
  first_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (trim_o == FIRST_CODE) && conv_valid_o);

  // R2
  cal_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid_o |-> cal_en_o);

  // R3
  trial_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (req_cnt == CNT_W'(TRIM_W)));

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o) && !busy_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  trim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !(start_i && offset_done_i)) |=> $stable(trim_o));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid_o && !conv_ready_i) |=> conv_valid_o && $stable(trim_o));

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_valid_o && res_ready_o));
endmodule

bind gain_trim_search gts_checker #(.TRIM_W(TRIM_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .offset_done_i (offset_done_i),
  .conv_valid_o  (conv_valid_o),
  .conv_ready_i  (conv_ready_i),
  .cal_en_o      (cal_en_o),
  .trim_o        (trim_o),
  .res_ready_o   (res_ready_o),
  .busy_o        (busy_o),
  .done_o        (done_o)
);

// File: tb/gain_trim_search_tb.sv
module gain_trim_search_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        offset_done_i = 1'b0;
  logic        neg_mode_i = 1'b0;
  logic [11:0] target_i = '0;
  logic        conv_valid_o;
  logic        conv_ready_i = 1'b0;
  logic        cal_en_o;
  logic [6:0]  trim_o;
  logic        res_valid_i = 1'b0;
  logic [11:0] res_data_i = '0;
  logic        res_ready_o;
  logic        busy_o;
  logic        done_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int req_count = 0;
  int first_trim = 0;
  int m_base = 0;
  int m_step = 1;
  bit m_neg = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gain_trim_search u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .offset_done_i(offset_done_i),
    .neg_mode_i(neg_mode_i), .target_i(target_i), .conv_valid_o(conv_valid_o),
    .conv_ready_i(conv_ready_i), .cal_en_o(cal_en_o), .trim_o(trim_o),
    .res_valid_i(res_valid_i), .res_data_i(res_data_i), .res_ready_o(res_ready_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  function automatic int model_code(input int t);
    int v;
    v = m_neg ? (m_base - t * m_step) : (m_base + t * m_step);
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  function automatic int expected_trim(input int tgt);
    for (int t = 127; t >= 0; t--) begin
      if (!m_neg && model_code(t) <= tgt) return t;
      if (m_neg && model_code(t) >= tgt) return t;
    end
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // converter model with random handshake delays
  initial begin
    forever begin
      @(negedge clk);
      if (conv_valid_o) begin
        int t;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        conv_ready_i = 1'b1;
        t = int'(trim_o);
        if (req_count == 0) first_trim = t;
        req_count++;
        @(negedge clk);
        conv_ready_i = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        res_valid_i = 1'b1;
        res_data_i = 12'(model_code(t));
        while (!res_ready_o) @(negedge clk);
        @(negedge clk);
        res_valid_i = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WDOG_LIMIT) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WDOG_LIMIT);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  task automatic run_search(input bit neg, input int tgt, input int base, input int step,
                            input bit poke);
    int exp;
    int waited;
    int final_trim;
    m_neg = neg; m_base = base; m_step = step;
    exp = expected_trim(tgt);
    req_count = 0;
    @(negedge clk);
    neg_mode_i = neg;
    target_i = 12'(tgt);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R6: change inputs after capture; result must still follow captured ones
    target_i = 12'($urandom_range(0, 4095));
    neg_mode_i = ~neg;
    check(busy_o == 1'b1, "R7 busy after start", busy_o, 1);
    check(conv_valid_o == 1'b1 && cal_en_o == 1'b1, "R2 first request with cal enable",
          {conv_valid_o, cal_en_o}, 3);
    check(trim_o == 7'h40, "R2 first trial code", trim_o, 'h40);
    if (poke) begin
      repeat (5) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    waited = 0;
    while (!done_o && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    check(done_o == 1'b1, "R8 done reached", done_o, 1);
    check(busy_o == 1'b0, "R8 busy low at done", busy_o, 0);
    check(req_count == 7, "R3 seven conversions", req_count, 7);
    check(first_trim == 'h40, "R2 first requested code", first_trim, 'h40);
    check(int'(trim_o) == exp, neg ? "R5 negative mode final code" : "R4 normal mode final code",
          trim_o, exp);
    final_trim = int'(trim_o);
    @(negedge clk);
    check(done_o == 1'b0, "R8 done single cycle", done_o, 0);
    repeat (3) @(negedge clk);
    check(int'(trim_o) == final_trim, "R8 trim held after done", trim_o, final_trim);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    check(!busy_o && !done_o && !conv_valid_o && !res_ready_o && !cal_en_o && trim_o == 0,
          "R10 reset state", {busy_o, done_o, conv_valid_o, res_ready_o, cal_en_o, trim_o}, 0);

    // R1: refused start without offset calibration
    offset_done_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(!busy_o && !conv_valid_o, "R1 start refused", {busy_o, conv_valid_o}, 0);
    check(trim_o == 0, "R1 trim unchanged", trim_o, 0);

    offset_done_i = 1'b1;
    // directed corners
    run_search(1'b0, 12'hFFD, 0, 32, 1'b0);       // R4 all bits kept -> 127
    run_search(1'b0, 100, 4000, 1, 1'b0);         // R4 none qualify -> 0
    run_search(1'b1, 12'h002, 4095, 32, 1'b0);    // R5 all kept
    run_search(1'b1, 4000, 100, 3, 1'b0);         // R5 none qualify -> 0
    run_search(1'b0, 12'hFFD, 1000, 25, 1'b1);    // R7 start while busy ignored

    // R1 again after a completed search: trim must hold
    begin
      logic [6:0] held;
      held = trim_o;
      offset_done_i = 1'b0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(!busy_o, "R1 refused after search", busy_o, 0);
      check(trim_o == held, "R1 trim kept on refusal", trim_o, held);
      offset_done_i = 1'b1;
    end

    // random searches
    for (int i = 0; i < 12; i++) begin
      bit n;
      n = 1'($urandom_range(0, 1));
      if (n)
        run_search(1'b1, $urandom_range(0, 200), $urandom_range(2000, 4095),
                   $urandom_range(1, 40), 1'($urandom_range(0, 1)));
      else
        run_search(1'b0, $urandom_range(3800, 4095), $urandom_range(0, 2000),
                   $urandom_range(1, 40), 1'($urandom_range(0, 1)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule